// File: doc/BRIEF.md
# Per-Pin Asymmetric Input Debouncer

This block filters a bank of already-synchronized input pins. Each pin is examined only on cycles where a shared sampling strobe is high, nominally once per millisecond. A pin keeps a filtered level and a small down-counter. A raw level that disagrees with the filtered level is accepted only after it has disagreed on a set number of consecutive sampling strobes. One count applies to leaving the low state and a separate count applies to leaving the high state. Any strobe on which the raw level agrees with the filtered level reloads the counter, so a short glitch starts the wait over.

When a change is accepted the pin can raise a one-cycle event. A pin in single-edge mode raises it only when the new level is its active level, which is high by default or low when the pin is configured active-low. A pin in double-edge mode raises it on every accepted change. After a synchronous reset every pin is inert and reads low. A per-pin initialise strobe arms the pin, takes the current raw value as its filtered level and loads the counter for leaving that level.

Top module: `pin_debounce_bank`

## Requirements
- R1: While a pin has not been initialised since reset, its filtered level reads 0 and its event output stays 0, whatever the raw input and sampling strobe do.
- R2: An initialise strobe on a pin sets its filtered level to the raw input in the next cycle and raises no event; it takes priority over a sampling strobe in the same cycle.
- R3: A raw change from 0 to 1 is accepted on the RISE_TICKS-th consecutive sampling strobe on which raw differs from the filtered level (3 by default), and not before.
- R4: A raw change from 1 to 0 is accepted on the FALL_TICKS-th consecutive differing sampling strobe (2 by default), and not before.
- R5: A sampling strobe on which raw equals the filtered level reloads the counter, so the full count is required again afterwards.
- R6: In cycles without a sampling strobe or initialise strobe, the filtered level and counter do not change, whatever the raw input does.
- R7: A pin with active-low bit 0 and double-edge bit 0 raises its event on an accepted 0-to-1 change only.
- R8: A pin with active-low bit 1 and double-edge bit 0 raises its event on an accepted 1-to-0 change only.
- R9: A pin with double-edge bit 1 raises its event on every accepted change, in both directions.
- R10: An event is high for exactly the one cycle in which the filtered level shows the new value, i.e. the cycle after the accepting strobe edge.
- R11: Pins are independent: bit i of every output depends only on bit i of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | Sampling strobe, one cycle per sampling period |
| raw_in | input | NUM_PINS | Synchronized raw pin levels |
| init_stb | input | NUM_PINS | Per-pin initialise strobe |
| act_low | input | NUM_PINS | Per-pin active level select, 1 = active low |
| dbl_edge | input | NUM_PINS | Per-pin double-edge event mode |
| filt_level | output | NUM_PINS | Filtered (debounced) level per pin |
| evt_pulse | output | NUM_PINS | One-cycle event per pin on accepted change |

## Verification
Four pins are configured active-high, active-low, double-edge and active-high, and are driven with staggered rising and falling changes so that each event rule is seen in both directions and pins changing in the same strobe are told apart from pins that must stay put. A rise that disappears one strobe before acceptance shows that agreement reloads the counter rather than merely pausing it, and raw changes held across cycles without a strobe show that only strobes advance the count. Reset with raw held high and strobes running shows uninitialised pins remain inert, and an initialise at raw high followed by a two-strobe fall shows the shorter falling count and the absence of an event on initialise.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    // Width of a counter that holds values up to max_val.
    function automatic int unsigned cnt_width(input int unsigned rise, input int unsigned fall);
        int unsigned m;
        m = (rise > fall) ? rise : fall;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

    // Event rule for an accepted change to new_lvl.
    function automatic logic fire_rule(input logic new_lvl, input logic low_act, input logic both);
        return both | (new_lvl ^ low_act);
    endfunction

endpackage

// File: rtl/dbn_event_qual.sv
module dbn_event_qual
    import dbn_pkg::*;
(
    input  logic new_lvl,
    input  logic low_act,
    input  logic both,
    output logic fire
);

    always_comb begin
        fire = fire_rule(new_lvl, low_act, both);
    end

    // R7 R8 R9: single-edge pin only fires toward its active level
    always_comb begin
        if (fire && !both) begin
            a_active_dir_r8: assert (new_lvl == !low_act);
        end
    end

endmodule

// File: rtl/dbn_pin_cell.sv
module dbn_pin_cell
    import dbn_pkg::*;
#(
    parameter int unsigned RISE_TICKS = 3,
    parameter int unsigned FALL_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic init,
    input  logic raw,
    input  logic low_act,
    input  logic both,
    output logic level,
    output logic evt
);

    localparam int unsigned CW = cnt_width(RISE_TICKS, FALL_TICKS);
    localparam logic [CW-1:0] RISE_C = CW'(RISE_TICKS);
    localparam logic [CW-1:0] FALL_C = CW'(FALL_TICKS);
    localparam logic [CW-1:0] MAX_C  = (RISE_C > FALL_C) ? RISE_C : FALL_C;

    typedef struct packed {
        logic          armed;
        logic          level;
        logic          evt;
        logic [CW-1:0] cnt;
    } cell_t;

    cell_t st_q, st_d;
    logic  fire;

    dbn_event_qual u_qual (
        .new_lvl (raw),
        .low_act (low_act),
        .both    (both),
        .fire    (fire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (init) begin
            st_d.armed = 1'b1;
            st_d.level = raw;
            st_d.cnt   = raw ? FALL_C : RISE_C;
        end else if (st_q.armed && tick) begin
            if (raw == st_q.level) begin
                st_d.cnt = st_q.level ? FALL_C : RISE_C;
            end else if (st_q.cnt <= CW'(1)) begin
                st_d.level = raw;
                st_d.cnt   = raw ? FALL_C : RISE_C;
                st_d.evt   = fire;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign evt   = st_q.evt;

    // R1: an unarmed pin is inert
    p_inert_unarmed_r1: assert property (@(posedge clk) disable iff (rst)
        !st_q.armed |-> (!st_q.level && !st_q.evt));

    // R3 R4: an armed counter stays within 1..max count
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.armed |-> (st_q.cnt >= CW'(1) && st_q.cnt <= MAX_C));

    // R6: level only moves after a strobe
    p_moves_on_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.level != $past(st_q.level)) |-> $past(tick || init));

    // R10: an event coincides with a change of level
    p_evt_on_change_r10: assert property (@(posedge clk) disable iff (rst)
        st_q.evt |-> (st_q.level != $past(st_q.level)));

    // R2: initialise never produces an event
    p_init_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        init |=> !st_q.evt);

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank #(
    parameter int unsigned NUM_PINS   = 8,
    parameter int unsigned RISE_TICKS = 3,
    parameter int unsigned FALL_TICKS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_tick,
    input  logic [NUM_PINS-1:0] raw_in,
    input  logic [NUM_PINS-1:0] init_stb,
    input  logic [NUM_PINS-1:0] act_low,
    input  logic [NUM_PINS-1:0] dbl_edge,
    output logic [NUM_PINS-1:0] filt_level,
    output logic [NUM_PINS-1:0] evt_pulse
);

    // R11: one independent cell per pin
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        dbn_pin_cell #(
            .RISE_TICKS (RISE_TICKS),
            .FALL_TICKS (FALL_TICKS)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .tick    (sample_tick),
            .init    (init_stb[gi]),
            .raw     (raw_in[gi]),
            .low_act (act_low[gi]),
            .both    (dbl_edge[gi]),
            .level   (filt_level[gi]),
            .evt     (evt_pulse[gi])
        );
    end

endmodule

// File: tb/tb_pin_debounce_bank.sv
module tb_pin_debounce_bank;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample_tick = 1'b0;
    logic [N-1:0] raw_in = '0;
    logic [N-1:0] init_stb = '0;
    logic [N-1:0] act_low;
    logic [N-1:0] dbl_edge;
    logic [N-1:0] filt_level;
    logic [N-1:0] evt_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pin_debounce_bank #(
        .NUM_PINS   (N),
        .RISE_TICKS (3),
        .FALL_TICKS (2)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .raw_in      (raw_in),
        .init_stb    (init_stb),
        .act_low     (act_low),
        .dbl_edge    (dbl_edge),
        .filt_level  (filt_level),
        .evt_pulse   (evt_pulse)
    );

    // pin0 active-high, pin1 active-low, pin2 double-edge, pin3 active-high
    assign act_low  = 4'b0010;
    assign dbl_edge = 4'b0100;

    // {req[3:0], raw[3:0], tick, exp_level[3:0], exp_evt[3:0]}
    localparam int NV = 21;
    localparam logic [16:0] VEC [NV] = '{
        {4'd3,  4'b0001, 1'b1, 4'b0000, 4'b0000}, // R3 first differing strobe
        {4'd6,  4'b0001, 1'b0, 4'b0000, 4'b0000}, // R6 no strobe
        {4'd3,  4'b0001, 1'b1, 4'b0000, 4'b0000}, // R3 second strobe
        {4'd5,  4'b0000, 1'b1, 4'b0000, 4'b0000}, // R5 agree -> reload
        {4'd5,  4'b0001, 1'b1, 4'b0000, 4'b0000}, // R5 restart 1
        {4'd5,  4'b0001, 1'b1, 4'b0000, 4'b0000}, // R5 restart 2
        {4'd7,  4'b0001, 1'b1, 4'b0001, 4'b0001}, // R7 accepted rise, event
        {4'd10, 4'b0001, 1'b0, 4'b0001, 4'b0000}, // R10 event one cycle
        {4'd11, 4'b0111, 1'b1, 4'b0001, 4'b0000}, // R11 pins 1,2 start
        {4'd11, 4'b0111, 1'b1, 4'b0001, 4'b0000},
        {4'd9,  4'b0111, 1'b1, 4'b0111, 4'b0100}, // R9 dbl rise; R8 no evt on rise
        {4'd4,  4'b0110, 1'b1, 4'b0111, 4'b0000}, // R4 pin0 fall first
        {4'd7,  4'b0110, 1'b1, 4'b0110, 4'b0000}, // R7 no event on fall
        {4'd4,  4'b0000, 1'b1, 4'b0110, 4'b0000}, // R4
        {4'd8,  4'b0000, 1'b1, 4'b0000, 4'b0110}, // R8 low-act fall, R9 dbl fall
        {4'd10, 4'b0000, 1'b0, 4'b0000, 4'b0000}, // R10
        {4'd6,  4'b1000, 1'b0, 4'b0000, 4'b0000}, // R6 raw moves, no strobe
        {4'd6,  4'b1000, 1'b0, 4'b0000, 4'b0000}, // R6
        {4'd3,  4'b1000, 1'b1, 4'b0000, 4'b0000}, // R3
        {4'd3,  4'b1000, 1'b1, 4'b0000, 4'b0000}, // R3 not yet
        {4'd3,  4'b1000, 1'b1, 4'b1000, 4'b1000}  // R3 accepted on 3rd
    };

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic t, input logic [N-1:0] ini);
        @(negedge clk);
        raw_in      = r;
        sample_tick = t;
        init_stb    = ini;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset held with raw high and strobes running
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(4'b1111, 1'b1, 4'b0000);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 3; i++) step(4'b1111, 1'b1, 4'b0000);
        check("R1", "level before init", filt_level, 4'b0000);
        check("R1", "event before init", evt_pulse, 4'b0000);

        // R2: initialise at raw high, together with a strobe
        step(4'b1111, 1'b1, 4'b1111);
        check("R2", "level after init", filt_level, 4'b1111);
        check("R2", "no event on init", evt_pulse, 4'b0000);

        // R4: fall accepted on the second strobe
        step(4'b0000, 1'b1, 4'b0000);
        check("R4", "level after 1 fall strobe", filt_level, 4'b1111);
        check("R4", "event after 1 fall strobe", evt_pulse, 4'b0000);
        step(4'b0000, 1'b1, 4'b0000);
        check("R4", "level after 2 fall strobes", filt_level, 4'b0000);
        check("R8", "events on fall", evt_pulse, 4'b0110);

        // Re-reset and initialise at raw low for the table
        @(negedge clk); rst = 1'b1; sample_tick = 1'b0;
        step(4'b0000, 1'b0, 4'b0000);
        @(negedge clk); rst = 1'b0;
        step(4'b0000, 1'b0, 4'b1111);
        check("R2", "level after init low", filt_level, 4'b0000);

        for (int v = 0; v < NV; v++) begin
            logic [16:0] e;
            string rq;
            e = VEC[v];
            step(e[12:9], e[8], 4'b0000);
            rq = $sformatf("R%0d", e[16:13]);
            check(rq, $sformatf("vec %0d level", v), filt_level, e[7:4]);
            check(rq, $sformatf("vec %0d event", v), evt_pulse, e[3:0]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule